// File: doc/BRIEF.md
# Printer Strobe Transfer Controller

This block sits beside the register file of a sound generator whose two general-purpose I/O ports also serve a printer connection and floppy drive selection. Each time the port A register is written, the block compares the new strobe bit with the strobe value it remembered from the previous port A write. When that bit goes from high to low, the block hands the current port B byte to a printer-style output as a one-cycle valid pulse, together with a printer-busy interrupt pulse. On the alternate machine variant it also pulses an acknowledge interrupt.

The same port A writes also set two drive-activity indicators. The drive-select bits of port A are active low. A printing-enable input gates only the transfer. The remembered strobe is updated on every port A write, so the edge detection stays correct across periods with printing disabled.

The strobe memory is a two-state machine. `STB_LOW` means the last written strobe was low. `STB_HIGH` means it was high. On a port A write with bit 5 high, the machine goes to `STB_HIGH` from either state. On a write with bit 5 low, it goes to `STB_LOW`. A transfer fires only on the `STB_HIGH` to `STB_LOW` transition while printing is enabled. Cycles without a port A write keep the state.

Top module: `strobe_xfer_ctrl`

## Requirements
- R1: After reset, `xfer_valid`, `xfer_data`, `busy_irq`, `ack_irq`, `drive_a_on` and `drive_b_on` are all 0, and the stored strobe is low.
- R2: A port A write with bit 5 low, accepted while the stored strobe is high and `print_en` is 1, makes `xfer_valid` 1 for exactly the one clock cycle that follows the accepting edge.
- R3: No transfer happens on a port A write that has bit 5 high, or on a port A write made while the stored strobe is low.
- R4: While `print_en` is 0, no transfer happens. The stored strobe still takes bit 5 of each port A write, so a later enabled write with bit 5 low transfers if the preceding disabled write had bit 5 high.
- R5: On a transfer, `xfer_data` shows the `pb_val` sampled with the accepting write. It keeps that value until the next transfer.
- R6: `busy_irq` pulses for one cycle together with every `xfer_valid` pulse and at no other time.
- R7: `ack_irq` pulses together with `xfer_valid` only when `alt_variant` was 1 at the accepting write. Otherwise it stays 0.
- R8: On every port A write, `drive_a_on` becomes the inverse of port A bit 1 and `drive_b_on` becomes the inverse of port A bit 2. Between writes they hold.
- R9: Changes on `pa_val`, `pb_val`, `print_en` or `alt_variant` without `pa_wr` produce no pulse, do not move the indicators, and do not change the stored strobe.
- R10: The first port A write after reset never causes a transfer, whatever its strobe bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pa_wr | input | 1 | Port A register write accepted this cycle |
| pa_val | input | 8 | Value written to port A |
| pb_val | input | 8 | Current port B register contents |
| print_en | input | 1 | Printing enable |
| alt_variant | input | 1 | Alternate machine variant (adds acknowledge pulse) |
| xfer_valid | output | 1 | One-cycle byte transfer strobe |
| xfer_data | output | 8 | Transferred byte |
| busy_irq | output | 1 | Printer-busy interrupt pulse |
| ack_irq | output | 1 | Acknowledge interrupt pulse |
| drive_a_on | output | 1 | Drive A selected indicator |
| drive_b_on | output | 1 | Drive B selected indicator |

## Verification
The bench sweeps every pairing of previous and new strobe with every enable, variant and drive-select value. It also predicts each outcome from the requirements. A design that detected a level instead of an edge would fire on repeated low writes. A design that froze the strobe memory while printing was disabled would miss the transfer on the first enabled falling write after a disabled high write. A design that sampled strobe changes without a write would fire from idle bus noise. The bench also looks for a reset that starts the memory high, which would transfer on the first write, and for an acknowledge pulse that appears outside the alternate variant.

// File: rtl/strobe_xfer_pkg.sv
package strobe_xfer_pkg;
    parameter int BYTE_W = 8;

    typedef enum logic {
        STB_LOW  = 1'b0,
        STB_HIGH = 1'b1
    } stb_state_t;
endpackage

// File: rtl/strobe_fsm.sv
module strobe_fsm
    import strobe_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic new_strobe,
    input  logic enable,
    output logic fire
);
    stb_state_t state_q;
    stb_state_t state_d;

    // next-state and fire decision
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        if (wr) begin
            unique case (state_q)
                STB_LOW: begin
                    state_d = new_strobe ? STB_HIGH : STB_LOW;
                end
                STB_HIGH: begin
                    state_d = new_strobe ? STB_HIGH : STB_LOW;
                    fire    = enable && !new_strobe;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= STB_LOW;
        else        state_q <= state_d;
    end

    assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(state_q));
    assert_fire_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> enable);
endmodule

// File: rtl/drive_decode.sv
module drive_decode #(
    parameter int PORT_W  = 8,
    parameter int SEL_A   = 1,
    parameter int SEL_B   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [PORT_W-1:0] port_val,
    output logic              on_a,
    output logic              on_b
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_a <= 1'b0;
            on_b <= 1'b0;
        end else if (wr) begin
            on_a <= ~port_val[SEL_A];
            on_b <= ~port_val[SEL_B];
        end
    end

    assert_indicators_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(on_a) && $stable(on_b)));
endmodule

// File: rtl/xfer_out.sv
module xfer_out #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic          alt,
    input  logic [DW-1:0] byte_in,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic          irq_busy,
    output logic          irq_ack
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            data     <= '0;
            irq_busy <= 1'b0;
            irq_ack  <= 1'b0;
        end else begin
            valid    <= fire;
            irq_busy <= fire;
            irq_ack  <= fire && alt;
            if (fire) data <= byte_in;
        end
    end

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(data));
    assert_ack_with_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> irq_busy);
endmodule

// File: rtl/strobe_xfer_ctrl.sv
module strobe_xfer_ctrl
    import strobe_xfer_pkg::*;
#(
    parameter int DW        = BYTE_W,
    parameter int STB_BIT   = 5,
    parameter int DRV_A_BIT = 1,
    parameter int DRV_B_BIT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pa_wr,
    input  logic [DW-1:0] pa_val,
    input  logic [DW-1:0] pb_val,
    input  logic          print_en,
    input  logic          alt_variant,
    output logic          xfer_valid,
    output logic [DW-1:0] xfer_data,
    output logic          busy_irq,
    output logic          ack_irq,
    output logic          drive_a_on,
    output logic          drive_b_on
);
    logic fire;

    strobe_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (pa_wr),
        .new_strobe (pa_val[STB_BIT]),
        .enable     (print_en),
        .fire       (fire)
    );

    xfer_out #(.DW(DW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .alt      (alt_variant),
        .byte_in  (pb_val),
        .valid    (xfer_valid),
        .data     (xfer_data),
        .irq_busy (busy_irq),
        .irq_ack  (ack_irq)
    );

    drive_decode #(.PORT_W(DW), .SEL_A(DRV_A_BIT), .SEL_B(DRV_B_BIT)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (pa_wr),
        .port_val (pa_val),
        .on_a     (drive_a_on),
        .on_b     (drive_b_on)
    );

    assert_fire_on_low_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> ($past(pa_wr) && !$past(pa_val[STB_BIT]) && $past(print_en)));
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> !xfer_valid);
    assert_busy_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_irq == xfer_valid);
endmodule

// File: tb/strobe_xfer_ctrl_bench.sv
module strobe_xfer_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pa_wr = 1'b0;
    logic [7:0] pa_val = 8'h00;
    logic [7:0] pb_val = 8'h00;
    logic       print_en = 1'b0;
    logic       alt_variant = 1'b0;
    logic       xfer_valid, busy_irq, ack_irq, drive_a_on, drive_b_on;
    logic [7:0] xfer_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic       m_prev = 1'b0;
    logic [7:0] m_data = 8'h00;
    logic       m_da = 1'b0;
    logic       m_db = 1'b0;

    always #4 clk = ~clk;

    strobe_xfer_ctrl u_strobe_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .pa_wr(pa_wr), .pa_val(pa_val), .pb_val(pb_val),
        .print_en(print_en), .alt_variant(alt_variant), .xfer_valid(xfer_valid),
        .xfer_data(xfer_data), .busy_irq(busy_irq), .ack_irq(ack_irq),
        .drive_a_on(drive_a_on), .drive_b_on(drive_b_on)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // check all outputs against the model; pulses expected given by fire/alt
    task automatic chk_all(input string req, input logic f, input logic a);
        chk({req, " valid"}, {7'd0, xfer_valid}, {7'd0, f});
        chk({req, " busy R6"}, {7'd0, busy_irq}, {7'd0, f});
        chk({req, " ack R7"}, {7'd0, ack_irq}, {7'd0, f & a});
        chk({req, " data R5"}, xfer_data, m_data);
        chk({req, " drvA R8"}, {7'd0, drive_a_on}, {7'd0, m_da});
        chk({req, " drvB R8"}, {7'd0, drive_b_on}, {7'd0, m_db});
    endtask

    task automatic pa_write(input logic [7:0] pa, input logic [7:0] pb,
                            input logic en, input logic alt, input string req);
        logic f;
        @(negedge clk);
        pa_val = pa; pb_val = pb; print_en = en; alt_variant = alt; pa_wr = 1'b1;
        f = m_prev && !pa[5] && en;
        m_prev = pa[5];
        if (f) m_data = pb;
        m_da = ~pa[1];
        m_db = ~pa[2];
        @(negedge clk);
        pa_wr = 1'b0;
        chk_all(req, f, alt);
        @(negedge clk);
        chk_all({req, " after R2"}, 1'b0, 1'b0);
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=<100000", wd);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 reset", 1'b0, 1'b0);

        // R10: first write after reset low strobe, enabled: no transfer
        pa_write(8'h00, 8'hA5, 1'b1, 1'b1, "R10 first write");

        // exhaustive sweep: previous strobe, new strobe, enable, variant, drive bits
        for (int p = 0; p < 2; p++)
            for (int s = 0; s < 2; s++)
                for (int e = 0; e < 2; e++)
                    for (int a = 0; a < 2; a++)
                        for (int d = 0; d < 4; d++) begin
                            logic [7:0] pb;
                            pb = 8'(p * 97 + s * 53 + e * 29 + a * 11 + d * 3 + 1);
                            // set previous strobe with printing disabled (R4 memory update)
                            pa_write({2'b00, p[0], 5'b00000}, 8'h3C, 1'b0, 1'b0, "R4 setup");
                            pa_write({2'b00, s[0], 2'b00, d[1:0], 1'b0}, pb, e[0], a[0],
                                     "R2 R3 R4 R7 R8 sweep");
                        end

        // R3 level low repeated: second low write must not fire
        pa_write(8'h20, 8'h11, 1'b1, 1'b0, "R3 high");
        pa_write(8'h00, 8'h22, 1'b1, 1'b0, "R2 fall");
        pa_write(8'h00, 8'h33, 1'b1, 1'b0, "R3 repeat low");

        // R9: idle stimulus without pa_wr
        pa_write(8'h26, 8'h44, 1'b1, 1'b1, "R9 setup high");
        @(negedge clk);
        pa_val = 8'h00; pb_val = 8'hEE; print_en = 1'b1; alt_variant = 1'b1;
        repeat (3) @(negedge clk);
        chk_all("R9 idle", 1'b0, 1'b0);
        // stored strobe still high: falling write now transfers
        pa_write(8'h06, 8'h5A, 1'b1, 1'b1, "R9 memory kept");

        // R1 again: reset clears memory
        pa_write(8'h20, 8'h01, 1'b1, 1'b0, "R1 pre");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_prev = 1'b0; m_data = 8'h00; m_da = 1'b0; m_db = 1'b0;
        @(negedge clk);
        chk_all("R1 reset again", 1'b0, 1'b0);
        pa_write(8'h00, 8'h77, 1'b1, 1'b1, "R10 after reset");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule